// File: doc/BRIEF.md
# Packed SIMD Lane Accumulator

This block keeps one wide signed accumulator per lane of a 64-bit packed vector datapath. Each lane is updated in a single cycle from two packed operands. It has two views of the same storage. In the byte view there are eight lanes: each takes unsigned 8-bit elements into a 24-bit accumulator. In the halfword view there are four lanes: each takes signed 16-bit elements into a 48-bit accumulator. A 3-bit operation code picks the arithmetic kind (sum, product, negated product or difference). Its low bit picks whether the result is added to the lane or replaces it.

There is a second way to set the accumulators: raw writes. A write-low loads a whole lane from two vectors. A write-high replaces only the top element-wide field of each lane. Any element-wide slice of every lane can be read back at once, packed into one 64-bit word. The readout is combinational from the stored state, so it shows the value before any update that is pending on the next clock edge.

Top module: `simd_lane_acc`

## Requirements
- R1: With fmt_i=0 the block works on eight byte lanes. Lane i uses operand bits [8i+7:8i] and accumulator bits [24i+23:24i]. Byte elements are zero-extended, so 0xF0+0x10 gives 0x000100 in that lane.
- R2: With fmt_i=1 the block works on four halfword lanes. Lane j uses operand bits [16j+15:16j] and accumulator bits [48j+47:48j]. Halfword elements are sign-extended, so 0x8000+0x8000 gives 0xFFFF_FFFF_0000.
- R3: op_i[2:1] picks the term: 0 sum a+b, 1 product a*b, 2 negated product, 3 difference. op_i[0]=0 adds the term to the lane; op_i[0]=1 replaces the lane with the term. This gives codes 0..7: add-acc, add-load, mul-acc, mul-load, msub-acc, msub-load, sub-acc, sub-load.
- R4: The negated-product load writes -(a*b). The negated-product accumulate subtracts a*b from the lane. Both difference forms use a minus b, where a is src_a_i and b is src_b_i.
- R5: slice_o returns, for every lane, the element-wide field at position slice_sel_i (0 low, 1 middle, 2 high) in the format given by fmt_i. Lane 0 sits at the least significant end. slice_sel_i=3 returns zero.
- R6: wr_lo_i sets each lane to {sign-extended element of src_a_i, element of src_b_i}. The src_b_i element fills the lowest 8 or 16 bits.
- R7: wr_hi_i replaces bits [23:16] of each byte lane, or bits [47:32] of each halfword lane, with the element of src_a_i. All lower bits are kept.
- R8: The asynchronous active-low reset clears every lane. With valid_i, wr_lo_i and wr_hi_i all low, the stored state does not change, whatever the other inputs do.
- R9: When several updates are requested in one cycle, wr_lo_i takes priority over wr_hi_i, and wr_hi_i takes priority over valid_i. slice_o shows the pre-update state until the clock edge.
- R10: Both formats share one 192-bit store. Changing fmt_i reinterprets the stored bits and does not clear them.
- R11: All arithmetic wraps modulo the lane width (24 or 48 bits) and never saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Apply the arithmetic operation on this edge |
| op_i | input | 3 | Operation code |
| fmt_i | input | 1 | 0 byte lanes, 1 halfword lanes (update and readout) |
| src_a_i | input | 64 | First packed operand, also the upper/high raw-write data |
| src_b_i | input | 64 | Second packed operand, also the low raw-write data |
| wr_lo_i | input | 1 | Raw write of whole lanes |
| wr_hi_i | input | 1 | Raw write of the top field of each lane |
| slice_sel_i | input | 2 | Slice position for readout |
| slice_o | output | 64 | Packed slice of every lane |

## Verification
Two pairs of functions can coincide in one cycle. The first is readout and update: the bench holds a write request in place and samples slice_o before the edge, expecting the old value, and again after the edge, expecting the new one. The second is several write requests at once: the bench raises wr_lo_i, wr_hi_i and valid_i in the same cycle, and then wr_hi_i together with valid_i. It judges which one took effect from the high and middle slices, because each candidate leaves a different pattern in them.

// File: rtl/simd_acc_pkg.sv
package simd_acc_pkg;
  localparam int VEC_W       = 64;
  localparam int BYTE_EW     = 8;
  localparam int BYTE_AW     = 24;
  localparam int HALF_EW     = 16;
  localparam int HALF_AW     = 48;
  localparam int SEL_W       = 2;
  localparam int BYTE_LANES  = VEC_W / BYTE_EW;
  localparam int HALF_LANES  = VEC_W / HALF_EW;
  localparam int ACC_BITS    = BYTE_LANES * BYTE_AW;

  typedef enum logic [1:0] {
    TERM_SUM  = 2'd0,
    TERM_PROD = 2'd1,
    TERM_NEGP = 2'd2,
    TERM_DIFF = 2'd3
  } term_e;
endpackage

// File: rtl/simd_acc_lane.sv
module simd_acc_lane #(
  parameter int EW     = 8,
  parameter int AW     = 24,
  parameter bit SIGNED = 1'b0
) (
  input  logic [AW-1:0] acc_i,
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic [2:0]    op_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  output logic [AW-1:0] next_o
);
  import simd_acc_pkg::*;

  localparam int XW = AW - EW;
  localparam int PW = XW - EW;

  logic [AW-1:0] a_x, b_x, prod, term, arith;
  term_e         kind;

  generate
    if (SIGNED) begin : g_sext
      assign a_x = {{XW{a_i[EW-1]}}, a_i};
      assign b_x = {{XW{b_i[EW-1]}}, b_i};
    end else begin : g_zext
      assign a_x = {{XW{1'b0}}, a_i};
      assign b_x = {{XW{1'b0}}, b_i};
    end
  endgenerate

  assign prod = a_x * b_x;
  assign kind = term_e'(op_i[2:1]);

  always_comb begin
    unique case (kind)
      TERM_SUM:  term = a_x + b_x;
      TERM_PROD: term = prod;
      TERM_NEGP: term = '0 - prod;
      default:   term = a_x - b_x;
    endcase
    arith = op_i[0] ? term : acc_i + term;
  end

  // raw writes override arithmetic; write-low first
  always_comb begin
    if (wr_lo_i)      next_o = {{PW{a_i[EW-1]}}, a_i, b_i};
    else if (wr_hi_i) next_o = {a_i, acc_i[XW-1:0]};
    else              next_o = arith;
  end
endmodule

// File: rtl/simd_acc_slice.sv
module simd_acc_slice #(
  parameter int LANES = 8,
  parameter int EW    = 8,
  parameter int AW    = 24,
  parameter int SEL_W = 2
) (
  input  logic [LANES*AW-1:0] acc_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [LANES*EW-1:0] slice_o
);
  localparam int SLICES = AW / EW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [AW-1:0] lane;
    assign lane = acc_i[l*AW +: AW];
    always_comb begin
      slice_o[l*EW +: EW] = '0;
      for (int s = 0; s < SLICES; s++) begin
        if (int'(sel_i) == s) slice_o[l*EW +: EW] = lane[s*EW +: EW];
      end
    end
  end
endmodule

// File: rtl/simd_lane_acc.sv
module simd_lane_acc
  import simd_acc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic             fmt_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [SEL_W-1:0] slice_sel_i,
  output logic [VEC_W-1:0] slice_o
);
  logic [ACC_BITS-1:0] acc_q, byte_next, half_next;
  logic [VEC_W-1:0]    byte_slice, half_slice;
  logic                upd;

  for (genvar i = 0; i < BYTE_LANES; i++) begin : g_byte
    simd_acc_lane #(.EW(BYTE_EW), .AW(BYTE_AW), .SIGNED(1'b0)) i_lane (
      .acc_i   (acc_q[i*BYTE_AW +: BYTE_AW]),
      .a_i     (src_a_i[i*BYTE_EW +: BYTE_EW]),
      .b_i     (src_b_i[i*BYTE_EW +: BYTE_EW]),
      .op_i    (op_i),
      .wr_lo_i (wr_lo_i),
      .wr_hi_i (wr_hi_i),
      .next_o  (byte_next[i*BYTE_AW +: BYTE_AW])
    );
  end

  for (genvar j = 0; j < HALF_LANES; j++) begin : g_half
    simd_acc_lane #(.EW(HALF_EW), .AW(HALF_AW), .SIGNED(1'b1)) i_lane (
      .acc_i   (acc_q[j*HALF_AW +: HALF_AW]),
      .a_i     (src_a_i[j*HALF_EW +: HALF_EW]),
      .b_i     (src_b_i[j*HALF_EW +: HALF_EW]),
      .op_i    (op_i),
      .wr_lo_i (wr_lo_i),
      .wr_hi_i (wr_hi_i),
      .next_o  (half_next[j*HALF_AW +: HALF_AW])
    );
  end

  assign upd = valid_i | wr_lo_i | wr_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  acc_q <= '0;
    else if (upd) acc_q <= fmt_i ? half_next : byte_next;
  end

  simd_acc_slice #(.LANES(BYTE_LANES), .EW(BYTE_EW), .AW(BYTE_AW), .SEL_W(SEL_W)) i_byte_rd (
    .acc_i   (acc_q),
    .sel_i   (slice_sel_i),
    .slice_o (byte_slice)
  );

  simd_acc_slice #(.LANES(HALF_LANES), .EW(HALF_EW), .AW(HALF_AW), .SEL_W(SEL_W)) i_half_rd (
    .acc_i   (acc_q),
    .sel_i   (slice_sel_i),
    .slice_o (half_slice)
  );

  assign slice_o = fmt_i ? half_slice : byte_slice;
endmodule

// File: rtl/simd_lane_acc_chk.sv
module simd_lane_acc_chk
  import simd_acc_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [2:0]          op_i,
  input logic                fmt_i,
  input logic [VEC_W-1:0]    src_a_i,
  input logic [VEC_W-1:0]    src_b_i,
  input logic                wr_lo_i,
  input logic                wr_hi_i,
  input logic [SEL_W-1:0]    slice_sel_i,
  input logic [VEC_W-1:0]    slice_o,
  input logic [ACC_BITS-1:0] acc_q
);
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i || wr_lo_i || wr_hi_i) |=> $stable(acc_q));

  a_r5_sel3_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slice_sel_i == 2'd3) |-> (slice_o == '0));

  a_r7_half_low_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i && fmt_i) |=> (acc_q[31:0] == $past(acc_q[31:0])));

  a_r7_byte_low_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i && !fmt_i) |=> (acc_q[15:0] == $past(acc_q[15:0])));

  a_r6_half_low_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && fmt_i) |=> (acc_q[15:0] == $past(src_b_i[15:0])));

  a_r3_byte_add_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wr_lo_i && !wr_hi_i && !fmt_i && op_i == 3'd1) |=>
    (acc_q[23:0] == 24'($past(src_a_i[7:0])) + 24'($past(src_b_i[7:0]))));
endmodule

bind simd_lane_acc simd_lane_acc_chk i_chk (.*);

// File: tb/test_simd_lane_acc.sv
module test_simd_lane_acc;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        fmt_i = 1'b0;
  logic [63:0] src_a_i = '0;
  logic [63:0] src_b_i = '0;
  logic        wr_lo_i = 1'b0;
  logic        wr_hi_i = 1'b0;
  logic [1:0]  slice_sel_i = '0;
  logic [63:0] slice_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  simd_lane_acc i_simd_lane_acc (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [2:0] op, input logic f,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic wl, input logic wh);
    @(negedge clk_i);
    valid_i = v; op_i = op; fmt_i = f; src_a_i = a; src_b_i = b;
    wr_lo_i = wl; wr_hi_i = wh;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0; wr_lo_i = 1'b0; wr_hi_i = 1'b0;
  endtask

  task automatic expect_slice(input string req, input logic f, input logic [1:0] s,
                              input logic [63:0] exp);
    fmt_i = f; slice_sel_i = s;
    #1;
    check(req, slice_o, exp);
  endtask

  task automatic t_reset;
    expect_slice("R8 reset sel0", 1'b0, 2'd0, 64'h0);
    expect_slice("R8 reset sel1", 1'b0, 2'd1, 64'h0);
    expect_slice("R8 reset sel2", 1'b1, 2'd2, 64'h0);
  endtask

  task automatic t_byte_arith;
    apply(1, 3'd1, 0, 64'hF7F6F5F4F3F2F1F0, 64'h1716151413121110, 0, 0);
    expect_slice("R1 add-load sel0", 0, 2'd0, 64'h0E0C0A0806040200);
    expect_slice("R1 add-load sel1", 0, 2'd1, 64'h0101010101010101);
    expect_slice("R1 add-load sel2", 0, 2'd2, 64'h0);
    apply(1, 3'd0, 0, 64'hF7F6F5F4F3F2F1F0, 64'h1716151413121110, 0, 0);
    expect_slice("R3 add-acc sel0", 0, 2'd0, 64'h1C1814100C080400);
    expect_slice("R3 add-acc sel1", 0, 2'd1, 64'h0202020202020202);
    apply(1, 3'd3, 0, {8{8'hFF}}, {8{8'hFF}}, 0, 0);
    expect_slice("R3 mul-load sel0", 0, 2'd0, {8{8'h01}});
    expect_slice("R3 mul-load sel1", 0, 2'd1, {8{8'hFE}});
    apply(1, 3'd4, 0, {8{8'hFF}}, {8{8'hFF}}, 0, 0);
    expect_slice("R4 msub-acc sel0", 0, 2'd0, 64'h0);
    expect_slice("R4 msub-acc sel1", 0, 2'd1, 64'h0);
    apply(1, 3'd5, 0, {8{8'h02}}, {8{8'h03}}, 0, 0);
    expect_slice("R4 msub-load sel0", 0, 2'd0, {8{8'hFA}});
    expect_slice("R4 msub-load sel2", 0, 2'd2, {8{8'hFF}});
    apply(1, 3'd6, 0, {8{8'h00}}, {8{8'h01}}, 0, 0);
    expect_slice("R4 sub-acc sel0", 0, 2'd0, {8{8'hF9}});
    apply(1, 3'd7, 0, {8{8'h05}}, {8{8'h07}}, 0, 0);
    expect_slice("R4 sub-load sel0", 0, 2'd0, {8{8'hFE}});
    expect_slice("R4 sub-load sel1", 0, 2'd1, {8{8'hFF}});
    apply(1, 3'd0, 0, {8{8'h01}}, {8{8'h02}}, 0, 0);
    expect_slice("R11 byte wrap sel0", 0, 2'd0, {8{8'h01}});
    expect_slice("R11 byte wrap sel2", 0, 2'd2, 64'h0);
    apply(1, 3'd2, 0, {8{8'h10}}, {8{8'h10}}, 0, 0);
    expect_slice("R3 mul-acc sel0", 0, 2'd0, {8{8'h01}});
    expect_slice("R3 mul-acc sel1", 0, 2'd1, {8{8'h01}});
  endtask

  task automatic t_half_arith;
    apply(1, 3'd1, 1, {4{16'h8000}}, {4{16'h8000}}, 0, 0);
    expect_slice("R2 sext add sel0", 1, 2'd0, 64'h0);
    expect_slice("R2 sext add sel1", 1, 2'd1, {4{16'hFFFF}});
    expect_slice("R2 sext add sel2", 1, 2'd2, {4{16'hFFFF}});
    apply(1, 3'd3, 1, {4{16'h8000}}, {4{16'h8000}}, 0, 0);
    expect_slice("R2 mul-load sel1", 1, 2'd1, {4{16'h4000}});
    expect_slice("R2 mul-load sel2", 1, 2'd2, 64'h0);
    apply(1, 3'd3, 1, {4{16'hFFFF}}, {4{16'h0003}}, 0, 0);
    expect_slice("R2 neg mul sel0", 1, 2'd0, {4{16'hFFFD}});
    expect_slice("R2 neg mul sel2", 1, 2'd2, {4{16'hFFFF}});
    apply(1, 3'd7, 1, 64'h0003000200010000, {4{16'h0010}}, 0, 0);
    expect_slice("R4 half sub-load sel0", 1, 2'd0, 64'hFFF3FFF2FFF1FFF0);
    apply(0, 3'd0, 1, {4{16'hFFFF}}, {4{16'hFFFF}}, 1, 0);
    expect_slice("R6 half all-ones sel2", 1, 2'd2, {4{16'hFFFF}});
    apply(1, 3'd0, 1, {4{16'h0001}}, {4{16'h0001}}, 0, 0);
    expect_slice("R11 half wrap sel0", 1, 2'd0, {4{16'h0001}});
    expect_slice("R11 half wrap sel2", 1, 2'd2, 64'h0);
    apply(1, 3'd4, 1, {4{16'hFFFF}}, {4{16'h0002}}, 0, 0);
    expect_slice("R4 half msub-acc sel0", 1, 2'd0, {4{16'h0003}});
    expect_slice("R4 half msub-acc sel2", 1, 2'd2, 64'h0);
  endtask

  task automatic t_raw_writes;
    apply(0, 3'd0, 1, 64'h8001123480011234, {4{16'h5678}}, 1, 0);
    expect_slice("R6 half wr-lo sel0", 1, 2'd0, {4{16'h5678}});
    expect_slice("R6 half wr-lo sel1", 1, 2'd1, 64'h8001123480011234);
    expect_slice("R6 half wr-lo sel2", 1, 2'd2, 64'hFFFF0000FFFF0000);
    apply(0, 3'd0, 1, {4{16'hABCD}}, 64'h0, 0, 1);
    expect_slice("R7 half wr-hi sel2", 1, 2'd2, {4{16'hABCD}});
    expect_slice("R7 half wr-hi sel1", 1, 2'd1, 64'h8001123480011234);
    expect_slice("R7 half wr-hi sel0", 1, 2'd0, {4{16'h5678}});
    apply(0, 3'd0, 0, {8{8'h80}}, {8{8'h11}}, 1, 0);
    expect_slice("R6 byte wr-lo sel0", 0, 2'd0, {8{8'h11}});
    expect_slice("R6 byte wr-lo sel1", 0, 2'd1, {8{8'h80}});
    expect_slice("R6 byte wr-lo sel2", 0, 2'd2, {8{8'hFF}});
    apply(0, 3'd0, 0, {8{8'h22}}, 64'h0, 0, 1);
    expect_slice("R7 byte wr-hi sel2", 0, 2'd2, {8{8'h22}});
    expect_slice("R7 byte wr-hi sel1", 0, 2'd1, {8{8'h80}});
    expect_slice("R7 byte wr-hi sel0", 0, 2'd0, {8{8'h11}});
  endtask

  task automatic t_format_switch;
    apply(0, 3'd0, 1, {4{16'h1234}}, {4{16'h5678}}, 1, 0);
    expect_slice("R10 byte view sel0", 0, 2'd0, 64'h1278127812781278);
    expect_slice("R10 byte view sel1", 0, 2'd1, 64'h0056005600560056);
    expect_slice("R10 half view kept", 1, 2'd1, {4{16'h1234}});
  endtask

  task automatic t_idle_and_sel3;
    @(negedge clk_i);
    valid_i = 1'b0; op_i = 3'd1; fmt_i = 1'b1;
    src_a_i = {4{16'h7777}}; src_b_i = {4{16'h1111}};
    repeat (3) @(posedge clk_i);
    #1;
    expect_slice("R8 idle hold sel0", 1, 2'd0, {4{16'h5678}});
    expect_slice("R8 idle hold sel1", 1, 2'd1, {4{16'h1234}});
    expect_slice("R5 sel3 byte zero", 0, 2'd3, 64'h0);
    expect_slice("R5 sel3 half zero", 1, 2'd3, 64'h0);
  endtask

  task automatic t_priority;
    // all three requests together: write-low wins
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 3'd1; fmt_i = 1'b1; slice_sel_i = 2'd1;
    src_a_i = {4{16'h1111}}; src_b_i = {4{16'h2222}};
    wr_lo_i = 1'b1; wr_hi_i = 1'b1;
    #1;
    check("R9 readout before edge", slice_o, {4{16'h1234}});
    @(posedge clk_i);
    #1;
    valid_i = 1'b0; wr_lo_i = 1'b0; wr_hi_i = 1'b0;
    expect_slice("R9 wr-lo wins sel1", 1, 2'd1, {4{16'h1111}});
    expect_slice("R9 wr-lo wins sel2", 1, 2'd2, 64'h0);
    expect_slice("R9 wr-lo wins sel0", 1, 2'd0, {4{16'h2222}});
    // write-high with arithmetic: write-high wins
    apply(1, 3'd1, 1, {4{16'h4444}}, {4{16'h0001}}, 0, 1);
    expect_slice("R9 wr-hi wins sel2", 1, 2'd2, {4{16'h4444}});
    expect_slice("R9 wr-hi wins sel0", 1, 2'd0, {4{16'h2222}});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_byte_arith();
    t_half_arith();
    t_raw_writes();
    t_format_switch();
    t_idle_and_sel3();
    t_priority();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule